// File: doc/BRIEF.md
# Uplink Channel Interleaver Address Sequencer

This block reorders a fixed group of 144 coded elements for an uplink shared channel. It treats the group as a matrix. The matrix has one row per allocated subcarrier, and the column count is 144 divided by the row count. The elements are filled in row by row and emptied column by column. The block holds no data storage of its own. It reads the source memory in strictly linear order through a read port. It writes each element to its permuted position in a destination memory through a write port.

Address generation does not use a row counter and a column counter. It uses one linear source counter and one destination pointer. The destination pointer steps by the row count modulo 144, and it takes one extra increment each time a column wraps. The first 143 elements are copied at one per clock. One cycle with no read then applies the final pointer step. The 144th element is copied after that cycle. A start strobe samples the row count. An illegal row count gives a one-cycle error pulse, and no memory access takes place. A one-cycle done pulse follows the last write.

Top module: `ilv_seq`

## Requirements
- R1: After reset, src_re, dst_we, done and cfg_err are all low.
- R2: For row counts 1, 3, 6 and 12, the element at source index r*(144/rows)+c is written to destination index r + c*rows. All 144 destinations are written exactly once.
- R3: Source reads run at indices 0 to 143 in increasing order. Each read index is one more than the one before it. The read port has one cycle of latency. Each write carries the data that the read in the previous cycle returned, and exactly 144 reads are made.
- R4: Every destination address lies below 144. The destination pointer advances by the row count. When the sum reaches 144 or more, it is reduced by 144 and then incremented by one.
- R5: Take the clock edge that samples start as cycle 0. Reads of indices 0 to 142 are issued in cycles 0 to 142. Cycle 143 has no read and applies the final pointer step. Index 143 is read in cycle 144. Each write comes one cycle after its read, so the writes fall in cycles 1 to 143 and cycle 145.
- R6: done is high for exactly one cycle, in cycle 146, the cycle after the write to destination 143.
- R7: A start with a row count outside {1, 3, 6, 12} pulses cfg_err in cycle 0. It makes no read, no write and no done pulse.
- R8: A start pulse that arrives while a copy is running is ignored. The running copy still makes exactly 144 writes and gives one done pulse.
- R9: The row count is sampled only on an accepted start. A change of cfg_rows during a copy does not alter that copy's permutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rows | input | RW (4) | Row count, equal to the allocated subcarrier count |
| start | input | 1 | Begin a copy. Sampled only when idle |
| src_re | output | 1 | Source read strobe |
| src_addr | output | AW (8) | Source read index |
| src_rdata | input | DW (8) | Source data, valid the cycle after src_re |
| dst_we | output | 1 | Destination write strobe |
| dst_addr | output | AW (8) | Destination write index |
| dst_wdata | output | DW (8) | Destination write data |
| done | output | 1 | One-cycle pulse after the final write |
| cfg_err | output | 1 | One-cycle pulse when a start carries an illegal row count |

## Verification
The bench targets the column wrap. A design that leaves out the extra increment writes one element twice and leaves a destination hole at every row boundary. It also targets the one-cycle bubble before the last element: a design that drops it or doubles it moves the final write and the done pulse off cycles 145 and 146. Row counts 1 and 12 are both covered. With a row count of 1 the pointer never wraps until the end. With 12 it wraps every 12 steps. Illegal counts, a start repeated during a copy, and a row count changed during a copy each expose a design that restarts or re-reads its configuration. Such a design corrupts the permutation or gives a second done pulse.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COPY,
    ST_FIX,
    ST_LAST,
    ST_TAIL
  } ilv_state_e;

  // Modulo step with the extra increment on a column wrap.
  function automatic logic [15:0] next_dst(input logic [15:0] cur,
                                           input logic [15:0] rows,
                                           input logic [15:0] n);
    logic [15:0] sum;
    sum = cur + rows;
    if (sum >= n) return sum - n + 16'd1;
    return sum;
  endfunction

  function automatic logic wraps(input logic [15:0] cur,
                                 input logic [15:0] rows,
                                 input logic [15:0] n);
    return (cur + rows) >= n;
  endfunction

endpackage

// File: rtl/ilv_cfg_latch.sv
module ilv_cfg_latch #(
  parameter int RW = 4,
  parameter logic [(1<<RW)-1:0] ROW_MASK = 16'h104A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] cfg_rows,
  output logic [RW-1:0] rows_q,
  output logic          legal
);
  assign legal = ROW_MASK[cfg_rows];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rows_q <= '0;
    else if (load) rows_q <= cfg_rows;
  end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int N_ELEM = 144,
  parameter int AW = 8,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv_src,
  input  logic          adv_dst,
  input  logic [RW-1:0] rows,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic          col_wrap
);
  localparam logic [15:0] N16 = 16'(N_ELEM);

  logic [15:0] dst_nxt;

  always_comb begin
    dst_nxt  = next_dst(16'(dst_ptr), 16'(rows), N16);
    col_wrap = adv_dst && wraps(16'(dst_ptr), 16'(rows), N16);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ptr <= '0;
      dst_ptr <= '0;
    end else if (clear) begin
      src_ptr <= '0;
      dst_ptr <= '0;
    end else begin
      if (adv_src) src_ptr <= src_ptr + AW'(1);
      if (adv_dst) dst_ptr <= dst_nxt[AW-1:0];
    end
  end
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int N_ELEM = 144,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          legal,
  input  logic [AW-1:0] src_ptr,
  output logic          load,
  output logic          clear,
  output logic          issue,
  output logic          adv_src,
  output logic          adv_dst,
  output logic          fix_step,
  output logic          last_issue,
  output logic          busy,
  output logic          cfg_err
);
  localparam logic [AW-1:0] PRE_LAST = AW'(N_ELEM - 2);

  ilv_state_e state_q, state_d;
  logic err_d;

  always_comb begin
    state_d    = state_q;
    load       = 1'b0;
    clear      = 1'b0;
    issue      = 1'b0;
    adv_src    = 1'b0;
    adv_dst    = 1'b0;
    fix_step   = 1'b0;
    last_issue = 1'b0;
    err_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        if (legal) begin
          load    = 1'b1;
          clear   = 1'b1;
          state_d = ST_COPY;
        end else begin
          err_d = 1'b1;
        end
      end
      ST_COPY: begin
        issue   = 1'b1;
        adv_src = 1'b1;
        if (src_ptr == PRE_LAST) state_d = ST_FIX;
        else                     adv_dst = 1'b1;
      end
      ST_FIX: begin
        fix_step = 1'b1;
        adv_dst  = 1'b1;
        state_d  = ST_LAST;
      end
      ST_LAST: begin
        issue      = 1'b1;
        last_issue = 1'b1;
        state_d    = ST_TAIL;
      end
      ST_TAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_err <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_err <= err_d;
    end
  end
endmodule

// File: rtl/ilv_wr_pipe.sv
module ilv_wr_pipe #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          last,
  input  logic [AW-1:0] dst_ptr,
  input  logic [DW-1:0] rdata,
  output logic          dst_we,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] dst_wdata,
  output logic          done
);
  logic last_q;

  assign dst_wdata = rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_we   <= 1'b0;
      dst_addr <= '0;
      last_q   <= 1'b0;
      done     <= 1'b0;
    end else begin
      dst_we <= issue;
      last_q <= issue && last;
      done   <= dst_we && last_q;
      if (issue) dst_addr <= dst_ptr;
    end
  end
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq #(
  parameter int N_ELEM = 144,
  parameter int DW = 8,
  parameter int RW = 4,
  parameter logic [(1<<RW)-1:0] ROW_MASK = 16'h104A,
  localparam int AW = $clog2(N_ELEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] cfg_rows,
  input  logic          start,
  output logic          src_re,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_rdata,
  output logic          dst_we,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] dst_wdata,
  output logic          done,
  output logic          cfg_err
);
  logic [RW-1:0] rows_q;
  logic          legal, load, clear, adv_src, adv_dst;
  logic [AW-1:0] src_ptr, dst_ptr;

  // Named internal events, observed by the checker.
  logic ev_issue, ev_fix, ev_last, ev_col_wrap, busy;

  ilv_cfg_latch #(.RW(RW), .ROW_MASK(ROW_MASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_rows(cfg_rows),
    .rows_q(rows_q), .legal(legal)
  );

  ilv_ctrl #(.N_ELEM(N_ELEM), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .legal(legal),
    .src_ptr(src_ptr), .load(load), .clear(clear), .issue(ev_issue),
    .adv_src(adv_src), .adv_dst(adv_dst), .fix_step(ev_fix),
    .last_issue(ev_last), .busy(busy), .cfg_err(cfg_err)
  );

  ilv_addr_gen #(.N_ELEM(N_ELEM), .AW(AW), .RW(RW)) u_addr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .adv_src(adv_src),
    .adv_dst(adv_dst), .rows(rows_q), .src_ptr(src_ptr),
    .dst_ptr(dst_ptr), .col_wrap(ev_col_wrap)
  );

  ilv_wr_pipe #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .issue(ev_issue), .last(ev_last),
    .dst_ptr(dst_ptr), .rdata(src_rdata), .dst_we(dst_we),
    .dst_addr(dst_addr), .dst_wdata(dst_wdata), .done(done)
  );

  assign src_re   = ev_issue;
  assign src_addr = src_ptr;
endmodule

// File: rtl/ilv_seq_chk.sv
module ilv_seq_chk #(
  parameter int N_ELEM = 144,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          src_re,
  input logic [AW-1:0] src_addr,
  input logic          dst_we,
  input logic [AW-1:0] dst_addr,
  input logic          done,
  input logic          cfg_err,
  input logic          ev_fix,
  input logic          ev_col_wrap,
  input logic          busy
);
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !src_re);

  a_r3_src_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (src_re && $past(src_re)) |-> (src_addr == $past(src_addr) + AW'(1)));

  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> $past(src_re));

  a_r4_dst_range: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (dst_addr < AW'(N_ELEM)));

  a_r4_wrap_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_col_wrap |-> busy);

  a_r5_fix_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fix |-> (!src_re && $past(src_re) && $past(src_addr) == AW'(N_ELEM - 2)));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(dst_we) && $past(dst_addr) == AW'(N_ELEM - 1)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_err_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($past(start) && !busy && !src_re && !dst_we));
endmodule

bind ilv_seq ilv_seq_chk #(.N_ELEM(N_ELEM), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_re(src_re),
  .src_addr(src_addr), .dst_we(dst_we), .dst_addr(dst_addr), .done(done),
  .cfg_err(cfg_err), .ev_fix(ev_fix), .ev_col_wrap(ev_col_wrap), .busy(busy)
);

// File: tb/sim_ilv_seq.sv
module sim_ilv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 144;
  localparam int DW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    cfg_rows = 4'd1;
  logic          start = 1'b0;
  logic          src_re, dst_we, done, cfg_err;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] src_rdata = '0;
  logic [DW-1:0] dst_wdata;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [DW-1:0] smem [N];
  logic [DW-1:0] dmem [N];
  bit            wflag [N];
  int            wtick [N];
  int tick = 0, wr_cnt = 0, dup_cnt = 0, rd_cnt = 0, done_cnt = 0, err_cnt = 0;
  int done_tick = 0, err_tick = 0, first_rd_tick = 0, last_rd_tick = 0, gaps = 0;
  int t0 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .start(start),
    .src_re(src_re), .src_addr(src_addr), .src_rdata(src_rdata),
    .dst_we(dst_we), .dst_addr(dst_addr), .dst_wdata(dst_wdata),
    .done(done), .cfg_err(cfg_err)
  );

  // Source memory with registered read
  always @(posedge clk) if (src_re) src_rdata <= smem[src_addr];

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    tick <= tick + 1;
    if (dst_we) begin
      if (dst_addr >= AW'(N)) dup_cnt <= dup_cnt + 1;
      else begin
        if (wflag[dst_addr]) dup_cnt <= dup_cnt + 1;
        wflag[dst_addr] <= 1'b1;
        dmem[dst_addr]  <= dst_wdata;
        wtick[dst_addr] <= tick + 1;
      end
      wr_cnt <= wr_cnt + 1;
    end
    if (src_re) begin
      if (rd_cnt == 0) first_rd_tick <= tick + 1;
      else if (tick + 1 != last_rd_tick + 1) gaps <= gaps + 1;
      last_rd_tick <= tick + 1;
      rd_cnt <= rd_cnt + 1;
    end
    if (done)    begin done_cnt <= done_cnt + 1; done_tick <= tick + 1; end
    if (cfg_err) begin err_cnt  <= err_cnt + 1;  err_tick  <= tick + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_dst(input int k, input int rows);
    int cols, r, c;
    cols = N / rows;
    r = k / cols;
    c = k % cols;
    return r + c * rows;
  endfunction

  task automatic clear_mon();
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) begin wflag[i] = 1'b0; wtick[i] = 0; end
    wr_cnt = 0; dup_cnt = 0; rd_cnt = 0; done_cnt = 0; err_cnt = 0; gaps = 0;
    done_tick = 0; err_tick = 0; first_rd_tick = 0; last_rd_tick = 0;
  endtask

  task automatic kick(input int rows);
    @(negedge clk); #1;
    cfg_rows = 4'(rows);
    start = 1'b1;
    @(posedge clk); #1;
    t0 = tick;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_copy(input int rows, input bit poke);
    int mism;
    for (int i = 0; i < N; i++) smem[i] = DW'($urandom);
    clear_mon();
    kick(rows);
    for (int i = 0; i < 160; i++) begin
      @(negedge clk); #1;
      if (poke && i == 40) begin start = 1'b1; cfg_rows = (rows == 12) ? 4'd1 : 4'd12; end
      if (poke && i == 41) start = 1'b0;
    end
    cfg_rows = 4'(rows);
    mism = 0;
    for (int k = 0; k < N; k++)
      if (!wflag[exp_dst(k, rows)] || dmem[exp_dst(k, rows)] !== smem[k]) mism++;
    chk(mism == 0, poke ? "R2/R8/R9 permutation" : "R2 permutation", mism, 0);
    chk(wr_cnt == N && dup_cnt == 0, "R4 writes once each", wr_cnt + 1000*dup_cnt, N);
    chk(rd_cnt == N, "R3 read count", rd_cnt, N);
    chk(first_rd_tick - t0 == 1 && gaps == 1, "R5 read timing", first_rd_tick - t0 + 100*gaps, 101);
    chk(wtick[0] - t0 == 2, "R5 first write", wtick[0] - t0, 2);
    chk(wtick[N-1] - t0 == 146, "R5 last write", wtick[N-1] - t0, 146);
    chk(done_cnt == 1, poke ? "R8 single done" : "R6 single done", done_cnt, 1);
    chk(done_tick - t0 == 147, "R6 done cycle", done_tick - t0, 147);
  endtask

  task automatic run_bad(input int rows);
    clear_mon();
    kick(rows);
    repeat (20) @(negedge clk);
    #1;
    chk(err_cnt == 1 && err_tick - t0 == 1, "R7 error pulse", err_tick - t0 + 100*err_cnt, 101);
    chk(wr_cnt == 0 && rd_cnt == 0 && done_cnt == 0, "R7 no access",
        wr_cnt + rd_cnt + done_cnt, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!src_re && !dst_we && !done && !cfg_err, "R1 reset outputs",
        int'({src_re, dst_we, done, cfg_err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!src_re && !dst_we && !done && !cfg_err, "R1 idle after reset",
        int'({src_re, dst_we, done, cfg_err}), 0);
    // Directed: each legal row count
    run_copy(1, 0);
    run_copy(3, 0);
    run_copy(6, 0);
    run_copy(12, 0);
    // Illegal counts
    run_bad(0);
    run_bad(2);
    run_bad(13);
    // Start and config change during copy
    run_copy(3, 1);
    run_copy(12, 1);
    // Random legal row counts
    for (int j = 0; j < 6; j++) begin
      int sel;
      sel = int'($urandom % 4);
      run_copy(sel == 0 ? 1 : sel == 1 ? 3 : sel == 2 ? 6 : 12, bit'($urandom % 2));
    end
    run_bad(int'($urandom % 2) == 0 ? 5 : 15);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule